// File: doc/BRIEF.md
# I2C Master Command and Receive Queues

This block holds the two queues that sit between a register interface and the byte-level engine of an I2C master. Software writes 9-bit words into a command queue: a word either carries a byte to transmit or asks the engine to read one byte from the bus. The engine takes words from the head of that queue one at a time. It pushes each byte it receives into a separate receive queue, which software drains by reading.

Both queues report their current fill level. Two comparisons against software-set thresholds produce level flags for an interrupt controller. Misuse of either queue produces one-cycle error pulses: writing to a full command queue, the engine pushing into a full receive queue, or reading an empty receive queue. A flush input empties both queues when a transfer aborts. The queue depth is a parameter and defaults to 8 entries.

Top module: `i2c_cmd_fifo`

## Requirements
- R1: A host write with bit 8 of `hostWrData` clear queues bits 7:0 as a transmit byte. The engine sees it at the head with `engTxIsRead`=0 and `engTxByte` equal to that byte, in the order written.
- R2: A host write with bit 8 set queues a read request. The engine sees `engTxIsRead`=1 and `engTxByte`=0, whatever bits 7:0 held.
- R3: `txLevel` and `rxLevel` give the number of stored entries. Each accepted push or pop changes the level on the clock edge that samples the strobe.
- R4: `hostRdData` shows the oldest received byte. Asserting `hostRdEn` removes that byte at the next edge.
- R5: `txEmptyFlag` is 1 while `txLevel` is less than or equal to `txThresh`.
- R6: `rxFullFlag` is 1 while `rxLevel` is greater than `rxThresh`. With `rxThresh`=0, a single stored byte raises it.
- R7: `flush` empties both queues at the next edge. It overrides any push or pop in the same cycle, and that cycle raises no error pulse.
- R8: A host write into a full command queue is dropped and the contents stay unchanged. `txOverflow` is 1 for the one cycle after that edge. A full queue refuses the write even if the engine pops in the same cycle.
- R9: While the receive queue is empty, `hostRdData` is 0. A read then raises `rxUnderflow` for the one cycle after the edge and leaves the level at 0.
- R10: An engine push into a full receive queue is dropped and the stored bytes stay unchanged. `rxOverflow` is 1 for the one cycle after that edge.
- R11: `engTxValid` is 1 exactly when the command queue holds an entry. An engine pop from an empty command queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host write strobe into the command queue |
| hostWrData | input | 9 | Bit 8 = read request, bits 7:0 = transmit byte |
| hostRdEn | input | 1 | Host read strobe, pops the receive queue |
| hostRdData | output | 8 | Oldest received byte, 0 when empty |
| txThresh | input | LW | Command queue threshold |
| rxThresh | input | LW | Receive queue threshold |
| flush | input | 1 | Abort flush of both queues |
| engTxPop | input | 1 | Engine takes the head command |
| engTxValid | output | 1 | Command queue holds an entry |
| engTxIsRead | output | 1 | Head command is a read request |
| engTxByte | output | 8 | Head command byte |
| engRxPush | input | 1 | Engine delivers a received byte |
| engRxByte | input | 8 | Received byte |
| txLevel | output | LW | Command queue fill level |
| rxLevel | output | LW | Receive queue fill level |
| txEmptyFlag | output | 1 | Command level at or below threshold |
| rxFullFlag | output | 1 | Receive level above threshold |
| txOverflow | output | 1 | Write into full command queue |
| rxUnderflow | output | 1 | Read of empty receive queue |
| rxOverflow | output | 1 | Push into full receive queue |

LW is $clog2(DEPTH+1), which is 4 for the default depth.

## Verification
Levels and error pulses are registered, so each is due one edge after the strobe that causes it. A pulse falls again one edge later. The head outputs, `hostRdData` and both threshold flags are combinational from stored state, so they follow in the same cycle that the level changes. The bench drives its strobes just after a rising edge and samples one nanosecond after the next rising edge. It reads the head values before it issues the pop that removes them.

// File: rtl/i2cfq_pkg.sv
package i2cfq_pkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
    logic clr;
  } qStrobes_t;

  // One command-queue entry
  typedef struct packed {
    logic       isRead;
    logic [7:0] data;
  } cmdEntry_t;

endpackage

// File: rtl/i2cfq_ring.sv
module i2cfq_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               wr,
  input  logic               rd,
  input  logic [WIDTH-1:0]   wdata,
  output logic [WIDTH-1:0]   head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic               full,
  output logic               empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr, wrNext, rdNext;
  logic [LW-1:0]    cnt;

  // Pointer wrap: free-running for power-of-two depths, compare otherwise
  generate
    if (POW2) begin : g_wrapFree
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrapCmp
      assign wrNext = (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (wr) wrPtr <= wrNext;
      if (rd) rdPtr <= rdNext;
      case ({wr, rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rdPtr];
  assign level = cnt;
  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/i2cfq_datapath.sv
module i2cfq_datapath
  import i2cfq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  qStrobes_t     stb,
  input  logic [8:0]    hostWrData,
  input  logic [7:0]    engRxByte,
  output cmdEntry_t     txHead,
  output logic [7:0]    rxHead,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel,
  output logic          txFull,
  output logic          txEmpty,
  output logic          rxFull,
  output logic          rxEmpty
);
  cmdEntry_t txIn;
  cmdEntry_t txOut;
  logic [7:0] rxOut;

  // A read request keeps no payload: the low byte is dropped here
  always_comb begin
    txIn.isRead = hostWrData[8];
    txIn.data   = hostWrData[8] ? 8'h00 : hostWrData[7:0];
  end

  i2cfq_ring #(.WIDTH($bits(cmdEntry_t)), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .clr(stb.clr), .wr(stb.txWr), .rd(stb.txRd),
    .wdata(txIn), .head(txOut), .level(txLevel), .full(txFull), .empty(txEmpty)
  );

  i2cfq_ring #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .clr(stb.clr), .wr(stb.rxWr), .rd(stb.rxRd),
    .wdata(engRxByte), .head(rxOut), .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );

  assign txHead = txEmpty ? '0 : txOut;
  assign rxHead = rxEmpty ? 8'h00 : rxOut;
endmodule

// File: rtl/i2cfq_ctrl.sv
module i2cfq_ctrl
  import i2cfq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic          hostRdEn,
  input  logic          engTxPop,
  input  logic          engRxPush,
  input  logic          flush,
  input  logic          txFull,
  input  logic          txEmpty,
  input  logic          rxFull,
  input  logic          rxEmpty,
  input  logic [LW-1:0] txLevel,
  input  logic [LW-1:0] rxLevel,
  input  logic [LW-1:0] txThresh,
  input  logic [LW-1:0] rxThresh,
  output qStrobes_t     stb,
  output logic          txEmptyFlag,
  output logic          rxFullFlag,
  output logic          txOverflow,
  output logic          rxUnderflow,
  output logic          rxOverflow
);
  // Flush has priority over every other strobe
  always_comb begin
    stb.clr  = flush;
    stb.txWr = hostWrEn  && !txFull  && !flush;
    stb.txRd = engTxPop  && !txEmpty && !flush;
    stb.rxWr = engRxPush && !rxFull  && !flush;
    stb.rxRd = hostRdEn  && !rxEmpty && !flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverflow  <= 1'b0;
      rxUnderflow <= 1'b0;
      rxOverflow  <= 1'b0;
    end else begin
      txOverflow  <= hostWrEn  && txFull  && !flush;
      rxUnderflow <= hostRdEn  && rxEmpty && !flush;
      rxOverflow  <= engRxPush && rxFull  && !flush;
    end
  end

  assign txEmptyFlag = (txLevel <= txThresh);
  assign rxFullFlag  = (rxLevel >  rxThresh);
endmodule

// File: rtl/i2c_cmd_fifo.sv
module i2c_cmd_fifo
  import i2cfq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [8:0]    hostWrData,
  input  logic          hostRdEn,
  output logic [7:0]    hostRdData,
  input  logic [LW-1:0] txThresh,
  input  logic [LW-1:0] rxThresh,
  input  logic          flush,
  input  logic          engTxPop,
  output logic          engTxValid,
  output logic          engTxIsRead,
  output logic [7:0]    engTxByte,
  input  logic          engRxPush,
  input  logic [7:0]    engRxByte,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel,
  output logic          txEmptyFlag,
  output logic          rxFullFlag,
  output logic          txOverflow,
  output logic          rxUnderflow,
  output logic          rxOverflow
);
  qStrobes_t stb;
  cmdEntry_t txHead;
  logic txFull, txEmpty, rxFull, rxEmpty;

  i2cfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .flush(flush),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txLevel(txLevel), .rxLevel(rxLevel), .txThresh(txThresh), .rxThresh(rxThresh),
    .stb(stb), .txEmptyFlag(txEmptyFlag), .rxFullFlag(rxFullFlag),
    .txOverflow(txOverflow), .rxUnderflow(rxUnderflow), .rxOverflow(rxOverflow)
  );

  i2cfq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrData(hostWrData),
    .engRxByte(engRxByte), .txHead(txHead), .rxHead(hostRdData),
    .txLevel(txLevel), .rxLevel(rxLevel), .txFull(txFull), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxEmpty(rxEmpty)
  );

  assign engTxValid  = !txEmpty;
  assign engTxIsRead = txHead.isRead;
  assign engTxByte   = txHead.data;
endmodule

// File: rtl/i2cfq_checker.sv
module i2cfq_checker #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostWrEn,
  input logic          hostRdEn,
  input logic [7:0]    hostRdData,
  input logic          flush,
  input logic          engTxValid,
  input logic          engTxIsRead,
  input logic [7:0]    engTxByte,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel,
  input logic          txOverflow,
  input logic          rxUnderflow,
  input logic          rxOverflow
);
  // R3: levels never exceed the depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txLevel) <= DEPTH) && (int'(rxLevel) <= DEPTH));

  // R3: without flush a level moves by at most one per edge
  p_level_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> (int'(rxLevel) <= int'($past(rxLevel)) + 1) &&
               (int'(txLevel) <= int'($past(txLevel)) + 1));

  // R7: flush leaves both queues empty
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (txLevel == '0) && (rxLevel == '0) && !txOverflow && !rxOverflow && !rxUnderflow);

  // R8: overflow pulse only after a write into a full queue
  p_tx_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOverflow) |-> $past(hostWrEn) && (int'($past(txLevel)) == DEPTH));

  // R9: underflow pulse only after a read of an empty queue
  p_rx_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxUnderflow) |-> $past(hostRdEn) && ($past(rxLevel) == '0));

  // R9: empty receive queue reads as zero
  p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0) |-> (hostRdData == 8'h00));

  // R10: a push into a full receive queue leaves the level at depth
  p_rx_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |-> (int'(rxLevel) == DEPTH) || (int'(rxLevel) == DEPTH - 1));

  // R2: read requests carry no payload
  p_read_no_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (engTxValid && engTxIsRead) |-> (engTxByte == 8'h00));

  // R11: valid tracks a non-zero level
  p_valid_level_r11: assert property (@(posedge clk) disable iff (!rstN)
    engTxValid == (txLevel != '0));
endmodule

bind i2c_cmd_fifo i2cfq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostRdData(hostRdData), .flush(flush), .engTxValid(engTxValid),
  .engTxIsRead(engTxIsRead), .engTxByte(engTxByte), .txLevel(txLevel),
  .rxLevel(rxLevel), .txOverflow(txOverflow), .rxUnderflow(rxUnderflow),
  .rxOverflow(rxOverflow)
);

// File: tb/i2c_cmd_fifo_test.sv
`timescale 1ns/1ps
module i2c_cmd_fifo_test;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH+1);
  localparam int NVEC = 6;
  // {command word[8:0], expected isRead, expected byte[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {9'h05A, 1'b0, 8'h5A},
    {9'h1C3, 1'b1, 8'h00},
    {9'h0FF, 1'b0, 8'hFF},
    {9'h100, 1'b1, 8'h00},
    {9'h000, 1'b0, 8'h00},
    {9'h1FF, 1'b1, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0, flush = 1'b0;
  logic engTxPop = 1'b0, engRxPush = 1'b0;
  logic [8:0] hostWrData = '0;
  logic [7:0] engRxByte = '0;
  logic [LW-1:0] txThresh = '0, rxThresh = '0;
  logic [7:0] hostRdData, engTxByte;
  logic engTxValid, engTxIsRead;
  logic [LW-1:0] txLevel, rxLevel;
  logic txEmptyFlag, rxFullFlag, txOverflow, rxUnderflow, rxOverflow;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_cmd_fifo #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hostWrite(input logic [8:0] d);
    hostWrEn = 1'b1; hostWrData = d; tick(); hostWrEn = 1'b0;
  endtask

  task automatic engPop(output logic isRd, output logic [7:0] b);
    isRd = engTxIsRead; b = engTxByte; engTxPop = 1'b1; tick(); engTxPop = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    engRxPush = 1'b1; engRxByte = b; tick(); engRxPush = 1'b0;
  endtask

  task automatic hostRead(output logic [7:0] b);
    b = hostRdData; hostRdEn = 1'b1; tick(); hostRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic rd;
    logic [7:0] b;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // Reset state
    chk("R3 reset txLevel", int'(txLevel), 0);
    chk("R3 reset rxLevel", int'(rxLevel), 0);
    chk("R11 reset engTxValid", int'(engTxValid), 0);
    chk("R5 reset txEmptyFlag", int'(txEmptyFlag), 1);
    chk("R6 reset rxFullFlag", int'(rxFullFlag), 0);
    chk("R9 reset hostRdData", int'(hostRdData), 0);

    // Vector table: R1, R2, R3
    for (int i = 0; i < NVEC; i++) begin
      hostWrite(VEC[i][17:9]);
      chk("R3 txLevel after push", int'(txLevel), i + 1);
    end
    for (int i = 0; i < NVEC; i++) begin
      chk("R11 engTxValid", int'(engTxValid), 1);
      engPop(rd, b);
      chk(VEC[i][8] ? "R2 isRead" : "R1 isRead", int'(rd), int'(VEC[i][8]));
      chk(VEC[i][8] ? "R2 byte" : "R1 byte", int'(b), int'(VEC[i][7:0]));
      chk("R3 txLevel after pop", int'(txLevel), NVEC - 1 - i);
    end
    // R11: pop on empty has no effect
    engTxPop = 1'b1; tick(); engTxPop = 1'b0;
    chk("R11 empty pop level", int'(txLevel), 0);
    chk("R11 empty valid", int'(engTxValid), 0);

    // R5: TX threshold
    txThresh = LW'(2);
    for (int i = 0; i < 3; i++) hostWrite(9'(8'h30 + i));
    chk("R5 above thresh", int'(txEmptyFlag), 0);
    engPop(rd, b);
    chk("R5 at thresh", int'(txEmptyFlag), 1);
    chk("R1 order", int'(b), 8'h30);

    // R6, R4: RX threshold and ordering
    chk("R6 empty rx flag", int'(rxFullFlag), 0);
    engPush(8'hA1);
    chk("R6 one byte thresh0", int'(rxFullFlag), 1);
    engPush(8'hB2);
    engPush(8'hC3);
    rxThresh = LW'(3);
    #1 chk("R6 level equal thresh", int'(rxFullFlag), 0);
    rxThresh = LW'(2);
    #1 chk("R6 level above thresh", int'(rxFullFlag), 1);
    hostRead(b); chk("R4 first", int'(b), 8'hA1);
    chk("R3 rxLevel after read", int'(rxLevel), 2);
    engPush(8'hD4);
    hostRead(b); chk("R4 second", int'(b), 8'hB2);

    // R7: flush with simultaneous strobes
    flush = 1'b1; hostWrEn = 1'b1; hostWrData = 9'h077; engRxPush = 1'b1; hostRdEn = 1'b1;
    tick();
    flush = 1'b0; hostWrEn = 1'b0; engRxPush = 1'b0; hostRdEn = 1'b0;
    chk("R7 txLevel", int'(txLevel), 0);
    chk("R7 rxLevel", int'(rxLevel), 0);
    chk("R7 no pulses", int'({txOverflow, rxOverflow, rxUnderflow}), 0);

    // R8: TX overflow
    for (int i = 0; i < DEPTH; i++) hostWrite(9'(8'h10 + i));
    chk("R8 full level", int'(txLevel), DEPTH);
    chk("R8 no early pulse", int'(txOverflow), 0);
    hostWrEn = 1'b1; hostWrData = 9'h0EE; engTxPop = 1'b1;
    tick();
    hostWrEn = 1'b0; engTxPop = 1'b0;
    chk("R8 pulse", int'(txOverflow), 1);
    chk("R8 level after drop", int'(txLevel), DEPTH - 1);
    tick();
    chk("R8 pulse falls", int'(txOverflow), 0);
    for (int i = 1; i < DEPTH; i++) begin
      engPop(rd, b);
      chk("R8 kept contents", int'(b), 8'h10 + i);
    end
    chk("R8 drained", int'(txLevel), 0);

    // R9: RX underflow
    chk("R9 empty data zero", int'(hostRdData), 0);
    hostRead(b);
    chk("R9 read value", int'(b), 0);
    chk("R9 pulse", int'(rxUnderflow), 1);
    chk("R9 level", int'(rxLevel), 0);
    tick();
    chk("R9 pulse falls", int'(rxUnderflow), 0);

    // R10: RX overflow
    for (int i = 0; i < DEPTH; i++) engPush(8'(8'h20 + i));
    engPush(8'h99);
    chk("R10 pulse", int'(rxOverflow), 1);
    chk("R10 level", int'(rxLevel), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(b);
      chk("R10 kept contents", int'(b), 8'h20 + i);
    end
    chk("R10 pulse cleared", int'(rxOverflow), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule